// File: doc/BRIEF.md
# Load-Use Hazard Stall Unit

This block sits beside the decode stage of a five-stage in-order pipeline. It watches the instruction in the execute-stage pipeline register. If that instruction is a memory load, its destination register number is compared with both source register numbers of the instruction now being decoded. The loaded value is not ready until the memory stage has read it, so the decoded instruction cannot proceed yet. In that case the unit freezes the program counter and the fetch/decode register for one cycle. It also tells the decode logic to zero every control field going into the execute-stage register, so that a no-op bubble enters execute in place of the dependent instruction.

After the one-cycle stall, the load's data can be forwarded to the dependent instruction, which is decoded a second time. The instruction behind it is fetched a second time. The stall decision is combinational, so it takes effect in the same cycle as the inputs that cause it. A one-bit history register makes sure that no stall ever lasts longer than one cycle.

Top module: `load_use_stall`

## Requirements
- R1: When there is no hazard, `pc_wr_en` = 1, `fd_wr_en` = 1 and `ex_bubble` = 0, in the same cycle as the inputs.
- R2: A hazard exists when `ex_is_load` = 1 and `ex_load_dst` equals `dec_src_a`.
- R3: A hazard exists when `ex_is_load` = 1 and `ex_load_dst` equals `dec_src_b`.
- R4: When `ex_is_load` = 0 there is never a stall, even if the register numbers match.
- R5: When `ex_is_load` = 1 but `ex_load_dst` equals neither source, there is no stall.
- R6: On a stall, all three outputs change together: `pc_wr_en` = 0, `fd_wr_en` = 0 and `ex_bubble` = 1.
- R7: A stall lasts exactly one cycle. In the cycle after a stall there is no stall, even if the hazard inputs are still present.
- R8: The synchronous active-high reset `rst` clears the stall history. A hazard in the first cycle after reset stalls, whatever happened just before reset.
- R9: In a pipeline built around the unit, a load followed directly by a dependent instruction produces exactly one bubble. A load followed by an independent instruction produces none. Every instruction reaches execute exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset of the stall history |
| ex_is_load | input | 1 | Instruction in the execute-stage register reads data memory |
| ex_load_dst | input | 5 | Destination register number of that instruction |
| dec_src_a | input | 5 | First source register number of the decoded instruction |
| dec_src_b | input | 5 | Second source register number of the decoded instruction |
| pc_wr_en | output | 1 | Program counter update enable |
| fd_wr_en | output | 1 | Fetch/decode register update enable |
| ex_bubble | output | 1 | Zero the control fields entering the execute-stage register |

## Verification
The bench goes after the matches on each source separately. A design that compared only one source would let a dependent instruction read a stale value. It also checks that a match is ignored when the execute-stage instruction is not a load; a design that got this wrong would stall needlessly on every register reuse. When the hazard inputs are held for two cycles, the second cycle must not stall, because a design that repeated the stall would insert two bubbles. A reset given just after a stall must clear the history, or the first hazard after reset would be missed. Short programs run through a model of the pipeline registers must show exactly one bubble per load-use pair and no lost or duplicated instructions.

// File: rtl/lus_pkg.sv
package lus_pkg;
    parameter int unsigned REG_IDX_W = 5;
    parameter int unsigned NUM_SRC   = 2;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef struct packed {
        logic pc_we;
        logic fd_we;
        logic bubble;
    } stall_ctrl_t;

    localparam stall_ctrl_t CTRL_RUN  = '{pc_we: 1'b1, fd_we: 1'b1, bubble: 1'b0};
    localparam stall_ctrl_t CTRL_HOLD = '{pc_we: 1'b0, fd_we: 1'b0, bubble: 1'b1};

    function automatic logic idx_equal(input reg_idx_t a, input reg_idx_t b);
        return a == b;
    endfunction
endpackage

// File: rtl/lus_src_match.sv
module lus_src_match
    import lus_pkg::*;
#(
    parameter int unsigned N_SRC = NUM_SRC
) (
    input  reg_idx_t load_dst,
    input  reg_idx_t srcs [N_SRC],
    output logic     any_hit
);
    logic [N_SRC-1:0] hit;

    for (genvar g = 0; g < N_SRC; g++) begin : g_cmp
        assign hit[g] = idx_equal(load_dst, srcs[g]);
    end

    assign any_hit = |hit;
endmodule

// File: rtl/lus_stall_seq.sv
module lus_stall_seq
    import lus_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        hazard,
    output stall_ctrl_t ctrl
);
    logic stalled_q;
    logic stall_now;

    // A stall in the previous cycle blocks a second one (R7)
    assign stall_now = hazard && !stalled_q;
    assign ctrl      = stall_now ? CTRL_HOLD : CTRL_RUN;

    always_ff @(posedge clk) begin
        if (rst) stalled_q <= 1'b0;
        else     stalled_q <= stall_now;
    end

    a_r7_single_cycle: assert property (@(posedge clk) disable iff (rst)
        ctrl.bubble |=> !ctrl.bubble);
endmodule

// File: rtl/load_use_stall.sv
module load_use_stall
    import lus_pkg::*;
(
    input  logic           clk,
    input  logic           rst,
    input  logic           ex_is_load,
    input  logic [4:0]     ex_load_dst,
    input  logic [4:0]     dec_src_a,
    input  logic [4:0]     dec_src_b,
    output logic           pc_wr_en,
    output logic           fd_wr_en,
    output logic           ex_bubble
);
    reg_idx_t    src_vec [NUM_SRC];
    logic        any_hit;
    logic        hazard;
    stall_ctrl_t ctrl;

    assign src_vec[0] = dec_src_a;
    assign src_vec[1] = dec_src_b;

    lus_src_match #(.N_SRC(NUM_SRC)) i_match (
        .load_dst (ex_load_dst),
        .srcs     (src_vec),
        .any_hit  (any_hit)
    );

    assign hazard = ex_is_load && any_hit;

    lus_stall_seq i_seq (
        .clk    (clk),
        .rst    (rst),
        .hazard (hazard),
        .ctrl   (ctrl)
    );

    assign pc_wr_en  = ctrl.pc_we;
    assign fd_wr_en  = ctrl.fd_we;
    assign ex_bubble = ctrl.bubble;

    a_r2_src_a_stall: assert property (@(posedge clk) disable iff (rst)
        (ex_is_load && ex_load_dst == dec_src_a && !$past(ex_bubble)) |-> ex_bubble);

    a_r3_src_b_stall: assert property (@(posedge clk) disable iff (rst)
        (ex_is_load && ex_load_dst == dec_src_b && !$past(ex_bubble)) |-> ex_bubble);

    a_r4_no_load_runs: assert property (@(posedge clk) disable iff (rst)
        !ex_is_load |-> (pc_wr_en && fd_wr_en && !ex_bubble));

    a_r5_no_match_runs: assert property (@(posedge clk) disable iff (rst)
        (ex_load_dst != dec_src_a && ex_load_dst != dec_src_b) |-> !ex_bubble);

    a_r8_reset_clears: assert property (@(posedge clk) disable iff (rst)
        ($past(rst) && ex_is_load && ex_load_dst == dec_src_a) |-> ex_bubble);
endmodule

// File: tb/test_load_use_stall.sv
module test_load_use_stall;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ex_is_load = 1'b0;
    logic [4:0] ex_load_dst = '0, dec_src_a = '0, dec_src_b = '0;
    logic pc_wr_en, fd_wr_en, ex_bubble;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    load_use_stall i_load_use_stall (
        .clk(clk), .rst(rst), .ex_is_load(ex_is_load), .ex_load_dst(ex_load_dst),
        .dec_src_a(dec_src_a), .dec_src_b(dec_src_b),
        .pc_wr_en(pc_wr_en), .fd_wr_en(fd_wr_en), .ex_bubble(ex_bubble)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // stall expected: outputs {pc,fd,bubble} = 3'b001, else 3'b110 (R6/R1)
    task automatic chk_outs(input string req, input bit stall);
        chk(req, {pc_wr_en, fd_wr_en, ex_bubble}, stall ? 3'b001 : 3'b110);
    endtask

    task automatic drive(input bit ld, input int dst, input int a, input int b);
        ex_is_load = ld; ex_load_dst = 5'(dst); dec_src_a = 5'(a); dec_src_b = 5'(b);
    endtask

    typedef struct packed {
        logic       ld;
        logic [4:0] dst;
        logic [4:0] sa;
        logic [4:0] sb;
        logic       stall;
        logic [3:0] req;
    } vec_t;

    localparam vec_t VEC [10] = '{
        '{1'b1, 5'd3,  5'd3,  5'd9,  1'b1, 4'd2},
        '{1'b1, 5'd7,  5'd1,  5'd7,  1'b1, 4'd3},
        '{1'b1, 5'd12, 5'd12, 5'd12, 1'b1, 4'd6},
        '{1'b0, 5'd3,  5'd3,  5'd3,  1'b0, 4'd4},
        '{1'b0, 5'd8,  5'd2,  5'd8,  1'b0, 4'd4},
        '{1'b1, 5'd4,  5'd5,  5'd6,  1'b0, 4'd5},
        '{1'b1, 5'd31, 5'd30, 5'd15, 1'b0, 4'd5},
        '{1'b0, 5'd1,  5'd2,  5'd3,  1'b0, 4'd1},
        '{1'b1, 5'd31, 5'd0,  5'd31, 1'b1, 4'd3},
        '{1'b1, 5'd16, 5'd16, 5'd0,  1'b1, 4'd2}
    };

    typedef struct packed {
        logic       vld;
        logic       ld;
        logic [4:0] rs;
        logic [4:0] rt;
    } instr_t;

    localparam instr_t NOP = '{1'b0, 1'b0, 5'd0, 5'd0};
    instr_t prog [8];

    task automatic run_prog(input int n, input int exp_bubbles, input string tag);
        instr_t fd, ex;
        int pc, bubbles, issued;
        fd = NOP; ex = NOP; pc = 0; bubbles = 0; issued = 0;
        for (int c = 0; c < n + 6; c++) begin
            @(negedge clk);
            drive(ex.vld && ex.ld, ex.rt, fd.rs, fd.rt);
            #1;
            if (ex_bubble) bubbles++;
            if (ex_bubble) ex = NOP;
            else begin
                ex = fd;
                if (fd.vld) issued++;
            end
            if (fd_wr_en) fd = (pc < n) ? prog[pc] : NOP;
            if (pc_wr_en) pc++;
        end
        chk({"R9 bubbles ", tag}, bubbles, exp_bubbles);
        chk({"R9 issued ", tag}, issued, n);
    endtask

    initial begin
        repeat (2) @(negedge clk);
        #1;
        chk_outs("R1 reset state", 1'b0);
        rst = 1'b0;

        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            drive(1'b0, 0, 1, 2);
            @(negedge clk);
            drive(VEC[i].ld, VEC[i].dst, VEC[i].sa, VEC[i].sb);
            #1;
            chk_outs($sformatf("R%0d vector %0d", VEC[i].req, i), VEC[i].stall);
        end

        // R7: hazard held three cycles -> stall, run, stall
        @(negedge clk); drive(1'b0, 0, 0, 0);
        @(negedge clk); drive(1'b1, 9, 9, 1); #1;
        chk_outs("R7 first hazard cycle", 1'b1);
        @(negedge clk); #1;
        chk_outs("R7 cycle after stall", 1'b0);
        @(negedge clk); #1;
        chk_outs("R7 third cycle", 1'b1);

        // R8: stall, then reset, then hazard must stall again
        @(negedge clk); drive(1'b0, 0, 0, 0);
        @(negedge clk); drive(1'b1, 5, 2, 5); #1;
        chk_outs("R8 stall before reset", 1'b1);
        rst = 1'b1;
        @(negedge clk); rst = 1'b0; #1;
        chk_outs("R8 hazard after reset", 1'b1);

        // R9: pipeline model
        @(negedge clk); drive(1'b0, 0, 0, 0);
        prog[0] = '{1'b1, 1'b1, 5'd1, 5'd3};
        prog[1] = '{1'b1, 1'b0, 5'd3, 5'd4};
        run_prog(2, 1, "dependent pair");
        prog[0] = '{1'b1, 1'b1, 5'd1, 5'd3};
        prog[1] = '{1'b1, 1'b0, 5'd5, 5'd6};
        prog[2] = '{1'b1, 1'b0, 5'd3, 5'd7};
        run_prog(3, 0, "independent");
        prog[0] = '{1'b1, 1'b1, 5'd1, 5'd3};
        prog[1] = '{1'b1, 1'b1, 5'd3, 5'd7};
        prog[2] = '{1'b1, 1'b0, 5'd2, 5'd7};
        run_prog(3, 2, "load chain");

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule